// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the 8-bit status word of a small processor core, visible to software as one location in data memory. Its low four bits keep the arithmetic condition flags: carry, half (nibble) carry, zero and signed overflow. The ALU refreshes each of them through its own update enable whenever an instruction affects that flag, and software may overwrite them with an ordinary store.

Two further bits record power and watchdog history. The power-down flag goes high when the core executes its halt instruction and is cleared by the watchdog-clear instruction. The time-out flag goes high when the watchdog expires and is cleared by the watchdog-clear or halt instruction. Software stores cannot alter either one, so after a wake-up the code can read why the core restarted. Power-on reset clears the whole word. The core does not save the register on a call or on interrupt entry, so a service routine that needs the flags must copy them itself.

Top module: `status_flag_reg`

## Requirements
- R1: While the synchronous power-on reset `rst` is high, every bit of `status_q` is 0 after the next clock edge, whatever the other inputs are.
- R2: The bit positions in `status_q` are 0 = carry, 1 = nibble carry, 2 = zero, 3 = overflow, 4 = power-down, 5 = time-out. Bits 7:6 always read 0, even after a bus write with those bits set.
- R3: When `bus_we` is high and `bus_addr` equals `STATUS_ADDR` (default 0x0A), `status_q[3:0]` takes `bus_wdata[3:0]` at the next clock edge.
- R4: A bus write to any other address leaves all bits of `status_q` unchanged.
- R5: A bus write never changes `status_q[5:4]`.
- R6: For each i in 0..3, when `alu_flag_we[i]` is high, `status_q[i]` takes `alu_flag_val[i]` at the next edge. A flag whose enable is low keeps its value.
- R7: When a bus write to the register and an ALU update happen in the same cycle, the bus data wins for all of bits 3:0.
- R8: `halt_exec` sets the power-down bit and `wdt_clr` clears it. If both are high in the same cycle, halt wins and the bit is set.
- R9: `wdt_timeout` sets the time-out bit. Either `wdt_clr` or `halt_exec` clears it.
- R10: When `wdt_timeout` occurs in the same cycle as `wdt_clr` or `halt_exec`, the time-out bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | ADDR_W | Data-memory write address |
| bus_we | input | 1 | Data-memory write strobe |
| bus_wdata | input | 8 | Data-memory write data |
| alu_flag_we | input | 4 | Per-flag ALU update enables (carry, nibble carry, zero, overflow) |
| alu_flag_val | input | 4 | New ALU flag values, in the same bit order |
| wdt_clr | input | 1 | Watchdog-clear instruction executed |
| halt_exec | input | 1 | Halt instruction executed |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| status_q | output | 8 | Registered status value for reads |

## Verification
Assertions check on every cycle the rules that depend only on one cycle's inputs: the zero upper bits, bus data winning over the ALU, bus writes leaving the power bits unchanged, halt setting power-down, and time-out taking priority. What only the bench scenarios can show is how the bits change over sequences. Examples are a flag holding while its enable is low through many cycles, a time-out surviving a later halt-free stretch and then being cleared, and writes to neighbouring addresses leaving the whole word intact. A behavioural reference model is compared with the output on every clock during both the directed scenarios and the random stretch.

// File: rtl/status_reg_pkg.sv
package status_reg_pkg;
  localparam int NUM_ARITH = 4;
  localparam int WORD_W    = 8;
  localparam int POS_C   = 0;
  localparam int POS_AC  = 1;
  localparam int POS_Z   = 2;
  localparam int POS_OV  = 3;
  localparam int POS_PDF = 4;
  localparam int POS_TO  = 5;

  typedef struct packed {
    logic pdf;
    logic to;
  } pwr_flags_t;
endpackage

// File: rtl/arith_flag_bits.sv
module arith_flag_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_hit,
  input  logic [N-1:0] bus_bits,
  input  logic [N-1:0] upd_en,
  input  logic [N-1:0] upd_val,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            flags_q[i] <= 1'b0;
      else if (bus_hit)   flags_q[i] <= bus_bits[i];
      else if (upd_en[i]) flags_q[i] <= upd_val[i];
    end
  end

  // R7: the store wins over a simultaneous ALU update
  a_r7_bus_over_alu: assert property (@(posedge clk) disable iff (rst)
    (bus_hit && (upd_en != '0)) |=> (flags_q == $past(bus_bits)));

  // R6: a flag with its enable low and no store holds its value
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_hit && upd_en == '0) |=> $stable(flags_q));
endmodule

// File: rtl/power_flag_bits.sv
module power_flag_bits
  import status_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wdt_clr,
  input  logic       halt_exec,
  input  logic       wdt_timeout,
  output pwr_flags_t pwr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= '0;
    end else begin
      if (halt_exec)    pwr_q.pdf <= 1'b1;
      else if (wdt_clr) pwr_q.pdf <= 1'b0;

      if (wdt_timeout)               pwr_q.to <= 1'b1;
      else if (wdt_clr || halt_exec) pwr_q.to <= 1'b0;
    end
  end

  // R8: halt always leaves power-down set
  a_r8_halt_sets_pdf: assert property (@(posedge clk) disable iff (rst)
    halt_exec |=> pwr_q.pdf);

  // R10: time-out wins over clear and halt
  a_r10_timeout_wins: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> pwr_q.to);

  // R9: clear or halt without time-out leaves the time-out bit low
  a_r9_to_cleared: assert property (@(posedge clk) disable iff (rst)
    (!wdt_timeout && (wdt_clr || halt_exec)) |=> !pwr_q.to);
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_reg_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  STATUS_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  input  logic [3:0]        alu_flag_we,
  input  logic [3:0]        alu_flag_val,
  input  logic              wdt_clr,
  input  logic              halt_exec,
  input  logic              wdt_timeout,
  output logic [7:0]        status_q
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(STATUS_ADDR);

  logic             bus_hit;
  logic [NUM_ARITH-1:0] arith_q;
  pwr_flags_t       pwr_q;

  assign bus_hit = bus_we && (bus_addr == MATCH);

  arith_flag_bits #(.N(NUM_ARITH)) u_arith (
    .clk      (clk),
    .rst      (rst),
    .bus_hit  (bus_hit),
    .bus_bits (bus_wdata[NUM_ARITH-1:0]),
    .upd_en   (alu_flag_we),
    .upd_val  (alu_flag_val),
    .flags_q  (arith_q)
  );

  power_flag_bits u_power (
    .clk         (clk),
    .rst         (rst),
    .wdt_clr     (wdt_clr),
    .halt_exec   (halt_exec),
    .wdt_timeout (wdt_timeout),
    .pwr_q       (pwr_q)
  );

  always_comb begin
    status_q                      = '0;
    status_q[POS_OV:POS_C]        = arith_q;
    status_q[POS_PDF]             = pwr_q.pdf;
    status_q[POS_TO]              = pwr_q.to;
  end

  // R2: the unused upper bits never read 1
  a_r2_upper_zero: assert property (@(posedge clk) status_q[7:6] == 2'b00);

  // R5: a store with no system event leaves the power bits alone
  a_r5_bus_no_power: assert property (@(posedge clk) disable iff (rst)
    (bus_hit && !wdt_clr && !halt_exec && !wdt_timeout) |=> $stable(status_q[5:4]));

  // R3: a store loads the writable bits
  a_r3_store_loads: assert property (@(posedge clk) disable iff (rst)
    bus_hit |=> (status_q[3:0] == $past(bus_wdata[3:0])));
endmodule

// File: tb/status_flag_reg_test.sv
module status_flag_reg_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [3:0] alu_flag_we;
  logic [3:0] alu_flag_val;
  logic       wdt_clr, halt_exec, wdt_timeout;
  logic [7:0] status_q;

  int vectors = 0;
  int errors  = 0;
  int mdl_ar;
  int mdl_pdf;
  int mdl_to;

  always #2 clk = ~clk;

  status_flag_reg uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .alu_flag_we(alu_flag_we), .alu_flag_val(alu_flag_val),
    .wdt_clr(wdt_clr), .halt_exec(halt_exec), .wdt_timeout(wdt_timeout),
    .status_q(status_q)
  );

  function automatic int expected_word();
    return (mdl_to << 5) | (mdl_pdf << 4) | (mdl_ar & 15);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: status_q actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; bus_addr = 0; bus_we = 0; bus_wdata = 0;
    alu_flag_we = 0; alu_flag_val = 0;
    wdt_clr = 0; halt_exec = 0; wdt_timeout = 0;
  endtask

  // apply current inputs for one edge, update the model, compare after the edge
  task automatic step(input string tag);
    @(posedge clk);
    if (rst) begin
      mdl_ar = 0; mdl_pdf = 0; mdl_to = 0;
    end else begin
      if (bus_we && bus_addr == 8'h0A) mdl_ar = bus_wdata & 15;
      else for (int i = 0; i < 4; i++)
        if (alu_flag_we[i]) mdl_ar = alu_flag_val[i] ? (mdl_ar | (1 << i)) : (mdl_ar & ~(1 << i));
      if (halt_exec) mdl_pdf = 1;
      else if (wdt_clr) mdl_pdf = 0;
      if (wdt_timeout) mdl_to = 1;
      else if (wdt_clr || halt_exec) mdl_to = 0;
    end
    @(negedge clk);
    check(tag, status_q, expected_word());
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    mdl_ar = 0; mdl_pdf = 0; mdl_to = 0;
    idle();
    @(negedge clk);
    // R1: reset with every other input active
    rst = 1; bus_we = 1; bus_addr = 8'h0A; bus_wdata = 8'hFF;
    alu_flag_we = 4'hF; alu_flag_val = 4'hF; halt_exec = 1; wdt_timeout = 1;
    step("R1");
    check("R1", status_q, 0);
    idle();
    // R3 / R2: store with all bits set, upper bits stay 0
    bus_we = 1; bus_addr = 8'h0A; bus_wdata = 8'hFF; step("R3");
    check("R2", status_q & 8'hC0, 0);
    // R4: store elsewhere
    idle(); bus_we = 1; bus_addr = 8'h0B; bus_wdata = 8'h00; step("R4");
    bus_addr = 8'h8A; step("R4");
    check("R4", status_q, 8'h0F);
    // R6: single-flag updates, others hold
    idle(); alu_flag_we = 4'b0100; alu_flag_val = 4'b0000; step("R6");
    check("R6", status_q, 8'h0B);
    alu_flag_we = 4'b0001; alu_flag_val = 4'b1110; step("R6");
    check("R6", status_q, 8'h0A);
    idle(); step("R6");
    // R7: store beats ALU
    bus_we = 1; bus_addr = 8'h0A; bus_wdata = 8'h05;
    alu_flag_we = 4'hF; alu_flag_val = 4'hA; step("R7");
    check("R7", status_q, 8'h05);
    // R8: halt sets pdf and clears to; R5: store cannot clear it
    idle(); halt_exec = 1; step("R8");
    check("R8", status_q, 8'h15);
    idle(); bus_we = 1; bus_addr = 8'h0A; bus_wdata = 8'h00; step("R5");
    check("R5", status_q, 8'h10);
    // R9: timeout sets to, store cannot touch it
    idle(); wdt_timeout = 1; step("R9");
    check("R9", status_q, 8'h30);
    idle(); bus_we = 1; bus_addr = 8'h0A; bus_wdata = 8'h00; step("R5");
    check("R5", status_q, 8'h30);
    // R9: clear drops both
    idle(); wdt_clr = 1; step("R9");
    check("R9", status_q, 8'h00);
    // R8: halt and clear together -> pdf set
    idle(); halt_exec = 1; wdt_clr = 1; step("R8");
    check("R8", status_q, 8'h10);
    // R10: timeout with clear, then timeout with halt
    idle(); wdt_timeout = 1; wdt_clr = 1; step("R10");
    check("R10", status_q, 8'h20);
    idle(); wdt_timeout = 1; halt_exec = 1; step("R10");
    check("R10", status_q, 8'h30);
    // R9: halt alone clears to
    idle(); halt_exec = 1; step("R9");
    check("R9", status_q, 8'h10);
    // random stretch, model compared every clock (R3 R4 R6 R7 R8 R9 R10)
    for (int n = 0; n < 3000; n++) begin
      idle();
      rst          = ($urandom_range(0, 99) == 0);
      bus_we       = $urandom_range(0, 3) == 0;
      bus_addr     = ($urandom_range(0, 1) == 0) ? 8'h0A : 8'($urandom);
      bus_wdata    = 8'($urandom);
      alu_flag_we  = 4'($urandom);
      alu_flag_val = 4'($urandom);
      wdt_clr      = $urandom_range(0, 7) == 0;
      halt_exec    = $urandom_range(0, 7) == 0;
      wdt_timeout  = $urandom_range(0, 7) == 0;
      step("R3-model");
      check("R2", status_q & 8'hC0, 0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule